// File: doc/BRIEF.md
# Per-Group Access Policy Filter

This block holds one small control word for each of eight groups of bus masters and uses it to rule on every access those masters make. Each access comes in tagged with a 3-bit group number. The block looks up that group's word and gives one of three verdicts. It can block the access, let it through untranslated, or send it on to a lookup engine together with the base address of the group's in-memory structure.

Software sets up the group words through a simple register port. The port uses byte offsets, and each word is 32 bits wide. The verdict appears as three one-hot strobes one cycle after the access is presented, together with the base pointer when a lookup is needed. The lookup engine and memory sit outside this block.

Top module: `group_policy_filter`

## Requirements
- R1: After reset every group word reads as zero, and any access from any group gets the block verdict.
- R2: Group n's word is at byte offset 0x80 + 4*n for n = 0..7. A write to any other offset, including a misaligned one such as 0x81, changes no word. A read of such an offset returns zero.
- R3: A group word reads back with the structure base in bits 31:4, the pass-through flag in bit 1 and the enable flag in bit 0. Bits 3:2 always read as zero, whatever was written to them.
- R4: If the group's enable flag (bit 0) is 0, the access gets the block verdict, whatever the pass-through flag holds.
- R5: If enable = 1 and pass-through = 1, the access gets the pass verdict and the base output is zero. No lookup is requested, even for addresses outside any translated window.
- R6: If enable = 1 and pass-through = 0, the access gets the lookup verdict, and the base output equals the group's bits 31:4 with bits 3:0 forced to zero.
- R7: Every cycle with a valid access is followed, in the next cycle, by exactly one of the block, pass or lookup strobes for one cycle. A cycle without a valid access is followed by none of them.
- R8: When a write to the group's word and an access from that group fall in the same cycle, the verdict uses the word as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| acc_valid | input | 1 | An access is presented |
| acc_group | input | 3 | Group of the requesting master |
| dec_block | output | 1 | Block verdict strobe |
| dec_pass | output | 1 | Pass-through verdict strobe |
| dec_lookup | output | 1 | Lookup verdict strobe |
| dec_base | output | 32 | Structure pointer for a lookup, else zero |

## Verification
Random register writes, some to unmapped or misaligned offsets, are mixed with random accesses from all eight groups. Together they produce every combination of enable and pass-through flags. This shows that enable dominates pass-through, and that only the lookup verdict carries a pointer. Directed cases come first. Accesses right after reset must all be blocked. Writes that set the reserved bits show those bits read back as zero. Writes to an unmapped or misaligned offset are read back around them to show nothing changed. A write and an access to the same group in one cycle show the verdict comes from the old word, not the new one.

// File: rtl/group_policy_filter.sv
module group_policy_filter #(
  parameter int NGROUP = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_OFF = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic [$clog2(NGROUP)-1:0] acc_group,
  output logic              dec_block,
  output logic              dec_pass,
  output logic              dec_lookup,
  output logic [31:0]       dec_base
);
  localparam int GW   = $clog2(NGROUP);
  localparam int SPAN = NGROUP * 4;

  logic [27:0]       base_q [NGROUP];
  logic [NGROUP-1:0] pass_q;
  logic [NGROUP-1:0] act_q;

  logic [ADDR_W-1:0] off;
  logic              hit;
  logic [GW-1:0]     idx;

  assign off = cfg_addr - BASE_OFF;
  assign hit = (off < ADDR_W'(SPAN)) && (off[1:0] == 2'b00);
  assign idx = off[GW+1:2];

  wire unused_bits = &{1'b0, cfg_wdata[3:2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NGROUP; i++) base_q[i] <= '0;
      pass_q <= '0;
      act_q  <= '0;
    end else if (cfg_wr && hit) begin
      base_q[idx] <= cfg_wdata[31:4];
      pass_q[idx] <= cfg_wdata[1];
      act_q[idx]  <= cfg_wdata[0];
    end
  end

  assign cfg_rdata = hit ? {base_q[idx], 2'b00, pass_q[idx], act_q[idx]} : 32'h0;

  logic sel_act, sel_pass;
  assign sel_act  = act_q[acc_group];
  assign sel_pass = pass_q[acc_group];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_block  <= 1'b0;
      dec_pass   <= 1'b0;
      dec_lookup <= 1'b0;
      dec_base   <= '0;
    end else begin
      dec_block  <= acc_valid && !sel_act;
      dec_pass   <= acc_valid && sel_act && sel_pass;
      dec_lookup <= acc_valid && sel_act && !sel_pass;
      dec_base   <= (acc_valid && sel_act && !sel_pass) ? {base_q[acc_group], 4'h0} : 32'h0;
    end
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> $countones({dec_block, dec_pass, dec_lookup}) == 1); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !(dec_block || dec_pass || dec_lookup)); // R7
  AST_INACTIVE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !act_q[acc_group]) |=> dec_block); // R4
  AST_PASS_NO_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    dec_pass |-> dec_base == 32'h0); // R5
  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    dec_lookup |-> dec_base[3:0] == 4'h0); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[3:2] == 2'b00); // R3
  AST_OLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cfg_wr && hit && idx == acc_group && !act_q[acc_group]) |=> dec_block); // R8
endmodule

// File: tb/sim_group_policy_filter.sv
`timescale 1ns/1ps
module sim_group_policy_filter;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_wr = 0;
  logic [7:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic acc_valid = 0;
  logic [2:0] acc_group = 0;
  logic dec_block, dec_pass, dec_lookup;
  logic [31:0] dec_base;

  always #2 clk = ~clk;

  group_policy_filter u0 (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] model [8];
  logic [34:0] exp_q = '0;
  string exp_tag = "R1";

  function automatic bit mapped(input logic [7:0] a);
    return a >= 8'h80 && a <= 8'h9C && a[1:0] == 2'b00;
  endfunction

  function automatic logic [31:0] mread(input logic [7:0] a);
    if (!mapped(a)) return 32'h0;
    return model[a[4:2]] & 32'hFFFF_FFF3;
  endfunction

  function automatic logic [34:0] decide(input bit v, input logic [2:0] g);
    logic [31:0] w;
    w = model[g];
    if (!v) return '0;
    if (!w[0]) return {3'b100, 32'h0};
    if (w[1]) return {3'b010, 32'h0};
    return {3'b001, w[31:4], 4'h0};
  endfunction

  function automatic string tag_of(input logic [34:0] e);
    if (e[34]) return "R4";
    if (e[33]) return "R5";
    if (e[32]) return "R6";
    return "R7";
  endfunction

  task automatic chk(input string t, input logic [34:0] got, input logic [34:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", t, got, exp);
    end
  endtask

  task automatic cycle(input bit wr, input logic [7:0] a, input logic [31:0] d,
                       input bit v, input logic [2:0] g, input string t);
    logic [34:0] e;
    @(negedge clk);
    chk(exp_tag, {dec_block, dec_pass, dec_lookup, dec_base}, exp_q);
    cfg_wr = wr; cfg_addr = a; cfg_wdata = d; acc_valid = v; acc_group = g;
    #1;
    chk(t != "" ? t : (mapped(a) ? "R3" : "R2"), {3'b0, cfg_rdata}, {3'b0, mread(a)});
    e = decide(v, g);
    exp_q = e;
    exp_tag = (t == "R8") ? "R8" : tag_of(e);
    if (wr && mapped(a)) model[a[4:2]] = d;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: reset state, all reads zero and all groups blocked
    for (int i = 0; i < 8; i++) cycle(0, 8'h80 + 8'(4*i), 0, 1, 3'(i), "R1");
    // R3: reserved bits read zero; R5 pass; R6 lookup
    cycle(1, 8'h80, 32'hFFFF_FFFF, 0, 0, "R3");
    cycle(0, 8'h80, 0, 1, 0, "R3");
    cycle(1, 8'h84, 32'hABCD_E12D, 1, 0, "");
    cycle(0, 8'h84, 0, 1, 1, "R6");
    // R4: pass flag set but enable clear still blocks
    cycle(1, 8'h88, 32'h1234_5672, 0, 0, "");
    cycle(0, 8'h88, 0, 1, 2, "R4");
    // R2: unmapped and misaligned writes change nothing
    cycle(1, 8'h81, 32'hFFFF_FFFF, 0, 0, "R2");
    cycle(1, 8'hA0, 32'hFFFF_FFFF, 0, 0, "R2");
    cycle(1, 8'h7C, 32'hFFFF_FFFF, 0, 0, "R2");
    cycle(0, 8'h88, 0, 0, 0, "R2");
    cycle(0, 8'h9C, 0, 1, 7, "R2");
    // R8: write and access to same group in one cycle
    cycle(1, 8'h8C, 32'h5555_5551, 1, 3, "R8");
    cycle(1, 8'h8C, 32'h0000_0000, 1, 3, "R8");
    cycle(0, 8'h8C, 0, 1, 3, "R8");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      bit sc;
      a = ($urandom % 8 != 0) ? 8'h80 + 8'(4 * ($urandom % 8)) : 8'($urandom);
      sc = ($urandom % 4) == 0;
      cycle(($urandom % 3) == 0, a, $urandom, ($urandom % 4) != 0,
            sc ? a[4:2] : 3'($urandom), "");
    end
    cycle(0, 0, 0, 0, 0, "R7");
    cycle(0, 0, 0, 0, 0, "R7");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule